// File: doc/BRIEF.md
# Divided-Clock Idle Controller

This block puts a processor core into one of two low-power waiting modes and generates the clock enables that the rest of the core runs from. A request with the slow option selected sets the enables to a programmable fraction of the input clock, chosen from four powers of two. A request without that option keeps every enable at full rate and only waits. In both modes the block returns to normal operation when an interrupt arrives whose enable bit is set, and it marks the restart with a one-cycle resume strobe.

The core, serial, clock-output and timer enables all come from a single enable term, so they always run in lockstep. In slow idle the block only exits on a divided-clock boundary. No enable pulse is ever cut short, and the time to wake is bounded by the divisor.

Top module: `idle_clkdiv_ctrl`

## Requirements
- R1: After reset the block is running: all four enables are high, `in_idle` is low and `resume` is low.
- R2: The divisor select latched on entry to slow idle picks n as 16 for 2'b00, 32 for 2'b01, 64 for 2'b10 and 128 for 2'b11.
- R3: In slow idle the enables give a single one-cycle pulse every n input cycles. The first pulse comes in the n-th cycle after entry, and the enables are low in every other cycle.
- R4: The core, serial, clock-output and timer enables carry the same value in every cycle.
- R5: In slow idle, an enabled interrupt makes the block leave only after a cycle that carries an enable pulse. `resume` rises no more than n cycles after the interrupt cycle, even when the interrupt lasts a single cycle.
- R6: In plain idle the enables stay high in every cycle, and `resume` rises in the cycle after an enabled interrupt is presented.
- R7: An interrupt whose enable bit is clear has no effect in either idle mode: the block stays idle and the pulse pattern does not change.
- R8: `resume` is high for exactly one cycle, only in the first full-rate cycle after an idle mode, and `in_idle` is low in that cycle.
- R9: A request presented while already idle is ignored: the mode and the divisor stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | Enter an idle mode (sampled while running) |
| idle_div_en | input | 1 | 1 selects slow idle, 0 selects plain idle |
| div_sel | input | 2 | Divisor select for slow idle |
| irq_req | input | IRQ_N | Pending interrupt lines |
| irq_en | input | IRQ_N | Per-line interrupt enables |
| core_clk_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | Serial clock enable |
| clkout_en | output | 1 | Clock-output enable |
| tick_en | output | 1 | Timer tick enable |
| in_idle | output | 1 | High while in either idle mode |
| resume | output | 1 | One-cycle strobe on return to full rate |

## Verification
A wrong count or a wrong latched divisor changes the spacing of enable pulses, and that shows on the ports at the first pulse, n cycles after entry. A wake flag that is lost or set wrongly shows as a missing or early `resume` within one divisor period of the interrupt. Exits that do not fall on a pulse cycle show in the same cycle as a `resume` that does not follow a pulse. Every combination of divisor and interrupt phase is placed so that each of these faults shows within one period.

// File: rtl/idle_clkdiv_ctrl.sv
module idle_clkdiv_ctrl #(
  parameter int IRQ_N     = 8,
  parameter int BASE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             idle_div_en,
  input  logic [1:0]       div_sel,
  input  logic [IRQ_N-1:0] irq_req,
  input  logic [IRQ_N-1:0] irq_en,
  output logic             core_clk_en,
  output logic             sclk_en,
  output logic             clkout_en,
  output logic             tick_en,
  output logic             in_idle,
  output logic             resume
);

  localparam int CW = BASE_LOG2 + 3;
  localparam logic [CW-1:0] ONE = 1;

  typedef enum logic [1:0] {ST_RUN, ST_PLAIN, ST_SLOW} st_t;

  st_t           st;
  logic [CW-1:0] cnt, last;
  logic          wake_q, resume_q;

  wire irq_hit  = |(irq_req & irq_en);
  wire boundary = (st == ST_SLOW) && (cnt == last);
  wire en       = (st != ST_SLOW) || boundary;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      cnt      <= '0;
      last     <= '0;
      wake_q   <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      resume_q <= 1'b0;
      case (st)
        ST_RUN: if (idle_req) begin
          st     <= idle_div_en ? ST_SLOW : ST_PLAIN;
          cnt    <= '0;
          wake_q <= 1'b0;
          last   <= (ONE << (BASE_LOG2 + int'(div_sel))) - ONE;
        end
        ST_PLAIN: if (irq_hit) begin
          st       <= ST_RUN;
          resume_q <= 1'b1;
        end
        ST_SLOW: begin
          if (boundary && (wake_q || irq_hit)) begin
            st       <= ST_RUN;
            resume_q <= 1'b1;
            cnt      <= '0;
            wake_q   <= 1'b0;
          end else begin
            cnt <= boundary ? '0 : cnt + ONE;
            if (irq_hit) wake_q <= 1'b1;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign core_clk_en = en;
  assign sclk_en     = en;
  assign clkout_en   = en;
  assign tick_en     = en;
  assign in_idle     = (st != ST_RUN);
  assign resume      = resume_q;

  logic [CW:0] wait_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) wait_cnt <= '0;
    else if (st == ST_SLOW && (wake_q || irq_hit) && !boundary) wait_cnt <= wait_cnt + 1'b1;
    else wait_cnt <= '0;
  end

  AST_WAKE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= {1'b0, last}); // R5
  AST_EXIT_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && $past(st == ST_SLOW)) |-> $past(core_clk_en)); // R5
  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLOW && core_clk_en) |=> (!core_clk_en || resume)); // R3
  AST_RESUME_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume); // R8
  AST_RESUME_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> ($past(in_idle) && !in_idle)); // R8
  AST_PLAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PLAIN && !irq_hit) |=> (in_idle && !resume)); // R7

endmodule

// File: tb/idle_clkdiv_ctrl_tb_top.sv
`timescale 1ns/1ps
module idle_clkdiv_ctrl_tb_top;
  localparam int IRQ_N = 8;

  logic clk = 1'b0;
  logic rst_n, idle_req, idle_div_en;
  logic [1:0] div_sel;
  logic [IRQ_N-1:0] irq_req, irq_en;
  logic core_clk_en, sclk_en, clkout_en, tick_en, in_idle, resume;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  idle_clkdiv_ctrl #(.IRQ_N(IRQ_N), .BASE_LOG2(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_div_en(idle_div_en),
    .div_sel(div_sel), .irq_req(irq_req), .irq_en(irq_en),
    .core_clk_en(core_clk_en), .sclk_en(sclk_en), .clkout_en(clkout_en),
    .tick_en(tick_en), .in_idle(in_idle), .resume(resume));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_lockstep();
    logic [3:0] v;
    v = {core_clk_en, sclk_en, clkout_en, tick_en};
    chk(v == 4'b0000 || v == 4'b1111, "R4", int'(v), core_clk_en ? 15 : 0);
  endtask

  // {div code, interrupt offset, flags: bit0 = extra request while idle (R9), bit1 = masked line held (R7)}
  localparam logic [11:0] VEC [0:8] = '{
    {2'd0, 8'd0,   2'b00}, {2'd0, 8'd15,  2'b00}, {2'd0, 8'd20,  2'b10},
    {2'd1, 8'd5,   2'b00}, {2'd1, 8'd31,  2'b00}, {2'd2, 8'd64,  2'b00},
    {2'd3, 8'd0,   2'b00}, {2'd3, 8'd127, 2'b01}, {2'd3, 8'd130, 2'b11}};

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; idle_req = 1'b0; idle_div_en = 1'b0; div_sel = 2'd0;
    irq_req = '0; irq_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(core_clk_en && sclk_en && clkout_en && tick_en, "R1 enables", int'(core_clk_en), 1);
    chk(!in_idle, "R1 in_idle", int'(in_idle), 0);
    chk(!resume, "R1 resume", int'(resume), 0);

    for (int v = 0; v < 9; v++) begin
      int code, off, n, exp_idx;
      bit poke, masked;
      code = int'(VEC[v][11:10]); off = int'(VEC[v][9:2]);
      poke = VEC[v][0]; masked = VEC[v][1];
      n = 16 << code;                               // R2
      exp_idx = off + n - (off % n);
      idle_div_en = 1'b1; div_sel = 2'(code); idle_req = 1'b1;
      @(negedge clk);
      idle_req = 1'b0;
      irq_en = 8'h01;
      for (int idx = 0; ; idx++) begin
        chk_lockstep();
        if (idx == exp_idx) begin
          chk(resume, "R5 resume time", int'(resume), 1);
          chk(!in_idle && core_clk_en, "R8 full rate on resume", int'(in_idle), 0);
          break;
        end
        chk(!resume && in_idle, "R5/R7 still idle", int'(resume), 0);
        chk(core_clk_en == ((idx % n) == n - 1), "R3/R2 pulse pattern",
            int'(core_clk_en), int'((idx % n) == n - 1));
        irq_req[0] = (idx == off);
        irq_req[3] = masked;
        idle_req    = poke && (idx == 10);           // R9
        idle_div_en = !(poke && (idx == 10));
        div_sel     = (poke && (idx == 10)) ? 2'd0 : 2'(code);
        @(negedge clk);
      end
      irq_req = '0; idle_req = 1'b0; irq_en = '0;
      @(negedge clk);
      chk(!resume && !in_idle, "R8 single strobe", int'(resume), 0);
    end

    // Plain idle: full rate, masked lines ignored, wake in one cycle
    idle_div_en = 1'b0; idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0; irq_req = 8'h10; irq_en = 8'h01;
    for (int i = 0; i < 10; i++) begin
      chk(in_idle && !resume, "R7 plain masked", int'(in_idle), 1);
      chk(core_clk_en, "R6 plain full rate", int'(core_clk_en), 1);
      chk_lockstep();
      @(negedge clk);
    end
    irq_en = 8'h10;
    @(negedge clk);
    irq_req = '0; irq_en = '0;
    chk(resume && !in_idle, "R6 plain wake", int'(resume), 1);
    @(negedge clk);
    chk(!resume, "R8 plain strobe width", int'(resume), 0);

    // Reset while in slow idle returns to run state
    idle_div_en = 1'b1; div_sel = 2'd1; idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_idle && core_clk_en && !resume, "R1 reset from idle", int'(in_idle), 0);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule